// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking a radix tree of 64-bit entries held in memory. A single start pulse supplies the effective address and a root descriptor word. The descriptor word gives the root table base, the index width of the root level and the total number of address bits the tree covers. The walker then reads one entry per level through a request/response read port. Before each read it checks that the level's geometry is legal. It stops at the first leaf entry, at an invalid entry, or at an illegal level.

A walk ends in one of three ways, reported by a one-cycle `done` pulse. A successful walk returns the real address, the page size in address bits and the leaf entry. A walk that meets an invalid entry returns a no-entry fault. A walk that meets an illegal level returns a bad-configuration fault. In every case the address of the last entry read is also reported. The results stay on the outputs until the next accepted start. Memory latency can be any number of cycles.

Top module: `radix_walker`

## Requirements
- R1: After a synchronous reset the walker is idle: `busy`, `done`, `fault` and `rd_req` are 0, `cause` is 0, and `raddr`, `page_size`, `leaf_pte` and `last_addr` are all 0.
- R2: A `start` pulse is accepted only while `busy` is 0. A `start` that arrives during a walk has no effect on that walk's reads or results. No read request is issued while idle.
- R3: The descriptor word is decoded as follows. The total size is {bits 62:61, bits 7:5} + 31. The next-table base is the word masked with 0x0FFFFFFFFFFFFF00. The index width `w` is bits 4:0. At each level the entry address is base + 8 × ((EA >> (size − w)) mod 2^w), which is always 8-byte aligned.
- R4: Any bits of a table base below bit w+3 are cleared before the entry address is formed, and the walk goes on.
- R5: Each level is checked before its read. Level 0 needs size 52 and w 13. Levels 1 and 2 need w 9. Level 3 needs w 9 or 5. Level 4 and deeper are always illegal. A failed check ends the walk with `fault`=1 and `cause`=2, and no read is issued for that level.
- R6: An entry with bit 63 clear ends the walk with `fault`=1 and `cause`=1. A successful walk ends with `fault`=0 and `cause`=0.
- R7: After each valid entry the remaining size drops by that level's w. An entry with bit 62 set is a leaf. A non-leaf entry supplies the next base and the next w in the same layout as the descriptor word. On success, `page_size` is the remaining size, which lies between 12 and 39.
- R8: On a leaf, `leaf_pte` is the entry. `raddr` is (entry & 0x01FFFFFFFFFFF000 & ~(2^size−1)) | (EA & (2^size−1)). On a fault, `raddr`, `page_size` and `leaf_pte` are 0.
- R9: `done` is high for exactly one cycle per walk. `last_addr` is the address of the last entry requested, or 0 if none was requested. All results hold until the next accepted start.
- R10: Each level issues exactly one read. `rd_req` is a one-cycle pulse. The walker waits any number of cycles for `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk (accepted when idle) |
| ea | input | 64 | Effective address to translate |
| root_dw | input | 64 | Root descriptor: base, index width, size field |
| busy | output | 1 | A walk is in progress |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 64 | Address of the requested entry |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a fault |
| cause | output | 2 | 0 none, 1 invalid entry, 2 bad configuration |
| raddr | output | 64 | Translated real address |
| page_size | output | 7 | Page size in address bits |
| leaf_pte | output | 64 | Leaf entry of a successful walk |
| last_addr | output | 64 | Address of the last entry read |

## Verification
The assertions check several properties on every cycle:
- the read request and `done` are single-cycle pulses;
- no request is issued while idle;
- requests are 8-byte aligned;
- the cause code agrees with the fault flag;
- a fault flag rises only with `done`;
- a successful page size lies between 12 and 39;
- results stay stable while idle without a start.

Some behaviour only the bench's scenarios can show, by comparing against a reference walk over a bench-built tree. This covers the exact entry addresses and how many reads happen, the clearing of misaligned base bits, and the level geometry rules. It also covers how the real address is merged, which fault cause a walk reports, and that a start during a walk is ignored.

// File: rtl/radix_walker.sv
module radix_walker (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [63:0] ea,
  input  logic [63:0] root_dw,
  output logic        busy,
  output logic        rd_req,
  output logic [63:0] rd_addr,
  input  logic        rd_valid,
  input  logic [63:0] rd_data,
  output logic        done,
  output logic        fault,
  output logic [1:0]  cause,
  output logic [63:0] raddr,
  output logic [6:0]  page_size,
  output logic [63:0] leaf_pte,
  output logic [63:0] last_addr
);
  localparam logic [63:0] BASE_M = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN_M  = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [1:0]  C_NOPTE = 2'd1;
  localparam logic [1:0]  C_BADCFG = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [63:0] ea_q, base_q;
  logic [4:0]  w_q;
  logic [6:0]  size_q;
  logic [2:0]  lvl_q;

  logic        legal;
  logic [6:0]  shamt, nsize;
  logic [5:0]  align_bits;
  logic [63:0] idx, abase, eaddr, pmask, leaf_ra;

  assign busy = (st != S_IDLE);

  always_comb begin
    case (lvl_q)
      3'd0:        legal = (size_q == 7'd52) && (w_q == 5'd13);
      3'd1, 3'd2:  legal = (w_q == 5'd9);
      3'd3:        legal = (w_q == 5'd9) || (w_q == 5'd5);
      default:     legal = 1'b0;
    endcase
  end

  assign shamt      = size_q - {2'b00, w_q};
  assign align_bits = {1'b0, w_q} + 6'd3;
  assign idx        = (ea_q >> shamt) & ((64'd1 << w_q) - 64'd1);
  assign abase      = base_q & ~((64'd1 << align_bits) - 64'd1);
  assign eaddr      = abase + (idx << 3);
  assign nsize      = size_q - {2'b00, w_q};
  assign pmask      = (64'd1 << nsize) - 64'd1;
  assign leaf_ra    = (rd_data & RPN_M & ~pmask) | (ea_q & pmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ea_q      <= '0;
      base_q    <= '0;
      w_q       <= '0;
      size_q    <= '0;
      lvl_q     <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      cause     <= '0;
      raddr     <= '0;
      page_size <= '0;
      leaf_pte  <= '0;
      last_addr <= '0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ea_q      <= ea;
          base_q    <= root_dw & BASE_M;
          w_q       <= root_dw[4:0];
          size_q    <= {2'b00, root_dw[62:61], root_dw[7:5]} + 7'd31;
          lvl_q     <= '0;
          fault     <= 1'b0;
          cause     <= '0;
          raddr     <= '0;
          page_size <= '0;
          leaf_pte  <= '0;
          last_addr <= '0;
          st        <= S_ISSUE;
        end
        S_ISSUE: begin
          if (!legal) begin
            fault <= 1'b1;
            cause <= C_BADCFG;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else begin
            rd_req    <= 1'b1;
            rd_addr   <= eaddr;
            last_addr <= eaddr;
            st        <= S_WAIT;
          end
        end
        S_WAIT: if (rd_valid) begin
          if (!rd_data[63]) begin
            fault <= 1'b1;
            cause <= C_NOPTE;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else if (rd_data[62]) begin
            size_q    <= nsize;
            raddr     <= leaf_ra;
            page_size <= nsize;
            leaf_pte  <= rd_data;
            done      <= 1'b1;
            st        <= S_IDLE;
          end else begin
            size_q <= nsize;
            base_q <= rd_data & BASE_M;
            w_q    <= rd_data[4:0];
            lvl_q  <= lvl_q + 3'd1;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        rd_req,
  input logic [63:0] rd_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  cause,
  input logic [63:0] raddr,
  input logic [6:0]  page_size
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req); // R2
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[2:0] == 3'd0)); // R3
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (rst)
    fault |-> (cause == 2'd1 || cause == 2'd2)); // R5
  AST_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !fault |-> (cause == 2'd0)); // R6
  AST_FAULT_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> done); // R6
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (page_size >= 7'd12 && page_size <= 7'd39)); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(fault) && $stable(cause) && $stable(raddr) && $stable(page_size))); // R9
endmodule

bind radix_walker radix_walker_chk u_chk (.*);

// File: tb/radix_walker_bench.sv
`timescale 1ns/1ps
module radix_walker_bench;
  localparam logic [63:0] BM  = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN = 64'h01FF_FFFF_FFFF_F000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [63:0] ea_i = '0, dw_i = '0;
  logic busy, rd_req, rd_valid, done, fault;
  logic [63:0] rd_addr, rd_data, raddr, leaf_pte, last_addr;
  logic [1:0] cause;
  logic [6:0] page_size;

  int checks = 0, fails = 0;
  int lat_cfg = -1;
  int rd_count = 0;
  logic [63:0] first_addr = '0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] path [5];

  always #2.5 clk = ~clk;

  radix_walker u_radix_walker (
    .clk(clk), .rst(rst), .start(start), .ea(ea_i), .root_dw(dw_i),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .fault(fault), .cause(cause),
    .raddr(raddr), .page_size(page_size), .leaf_pte(leaf_pte),
    .last_addr(last_addr));

  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        logic [63:0] a;
        int lat;
        a = rd_addr;
        if (rd_count == 0) first_addr = a;
        rd_count++;
        lat = (lat_cfg < 0) ? int'($urandom_range(0, 3)) : lat_cfg;
        repeat (lat) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = mem.exists(a) ? mem[a] : 64'd0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] ea, input logic [63:0] dw,
      output logic [63:0] ra, output logic [63:0] pte, output logic [63:0] last,
      output logic [63:0] first, output int ps, output bit flt,
      output logic [1:0] cs, output int nrd);
    int psz, nl;
    bit ok;
    logic [63:0] base, e, a, idx;
    psz = int'({dw[62:61], dw[7:5]}) + 31;
    nl = int'(dw[4:0]);
    base = dw & BM;
    ra = '0; pte = '0; last = '0; first = '0; ps = 0; flt = 0; cs = 0; nrd = 0;
    for (int l = 0; l < 6; l++) begin
      case (l)
        0: ok = (psz == 52) && (nl == 13);
        1, 2: ok = (nl == 9);
        3: ok = (nl == 9) || (nl == 5);
        default: ok = 0;
      endcase
      if (!ok) begin flt = 1; cs = 2; return; end
      base = base & ~((64'd1 << (nl + 3)) - 64'd1);
      idx = (ea >> (psz - nl)) & ((64'd1 << nl) - 64'd1);
      a = base + idx * 8;
      if (nrd == 0) first = a;
      nrd++;
      last = a;
      e = mem.exists(a) ? mem[a] : 64'd0;
      if (!e[63]) begin flt = 1; cs = 1; return; end
      psz -= nl;
      if (e[62]) begin
        ra = (e & RPN & ~((64'd1 << psz) - 64'd1)) | (ea & ((64'd1 << psz) - 64'd1));
        pte = e;
        ps = psz;
        return;
      end
      base = e & BM;
      nl = int'(e[4:0]);
    end
  endfunction

  function automatic logic [63:0] build(input logic [63:0] ea, input int depth,
      input int l3w, input bit misalign);
    logic [63:0] dw, base, idx, a, e, nb;
    int psz, nl, nn;
    mem.delete();
    base = {$urandom, $urandom} & 64'h0000_00FF_FFFF_0000;
    if (misalign) base |= 64'h3300;
    dw = base | (64'd2 << 61) | (64'd5 << 5) | 64'd13;
    psz = 52; nl = 13;
    for (int l = 0; l <= depth && l < 5; l++) begin
      idx = (ea >> (psz - nl)) & ((64'd1 << nl) - 64'd1);
      a = (base & ~((64'd1 << (nl + 3)) - 64'd1)) + idx * 8;
      path[l] = a;
      psz -= nl;
      if (l == depth) begin
        e = (64'd3 << 62) | ({$urandom, $urandom} & RPN) | 64'(($urandom) & 32'h1FF);
      end else begin
        nn = (l + 1 == 3) ? l3w : 9;
        nb = {$urandom, $urandom} & 64'h0000_0FFF_FFFF_F000;
        if (misalign && l == 0) nb |= 64'h0A00;
        e = (64'd1 << 63) | nb | 64'(nn);
        base = nb; nl = nn;
      end
      mem[a] = e;
    end
    return dw;
  endfunction

  task automatic run(input logic [63:0] ea, input logic [63:0] dw, input bit extra, input string tag);
    logic [63:0] ra, pte, last, first, hold_ra;
    int ps, nrd, t;
    bit flt;
    logic [1:0] cs;
    model(ea, dw, ra, pte, last, first, ps, flt, cs, nrd);
    @(negedge clk);
    rd_count = 0;
    first_addr = '0;
    ea_i = ea; dw_i = dw; start = 1'b1;
    t = 0;
    forever begin
      @(negedge clk);
      start = extra && (t == 0);
      if (extra && t == 0) begin
        ea_i = ~ea;
        chk("R2", {tag, " busy at second start"}, 64'(busy), 64'd1);
      end
      if (done) break;
      t++;
      if (t > 2000) begin
        fails++;
        $display("FAIL R10 %s: actual no done expected done", tag);
        break;
      end
    end
    start = 1'b0;
    chk(flt ? (cs == 2 ? "R5" : "R6") : "R6", {tag, " fault"}, 64'(fault), 64'(flt));
    chk(flt ? (cs == 2 ? "R5" : "R6") : "R6", {tag, " cause"}, 64'(cause), 64'(cs));
    chk("R8", {tag, " raddr"}, raddr, ra);
    chk("R8", {tag, " leaf_pte"}, leaf_pte, pte);
    chk("R7", {tag, " page_size"}, 64'(page_size), 64'(ps));
    chk("R9", {tag, " last_addr"}, last_addr, last);
    chk("R10", {tag, " read count"}, 64'(rd_count), 64'(nrd));
    if (nrd > 0) chk("R3", {tag, " first entry addr"}, first_addr, first);
    hold_ra = raddr;
    repeat (3) @(negedge clk);
    chk("R9", {tag, " done pulse width"}, 64'(done), 64'd0);
    chk("R9", {tag, " raddr held"}, raddr, hold_ra);
  endtask

  initial begin
    logic [63:0] ea, dw;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "fault", 64'(fault), 64'd0);
    chk("R1", "rd_req", 64'(rd_req), 64'd0);
    chk("R1", "raddr", raddr, 64'd0);
    chk("R1", "last_addr", last_addr, 64'd0);
    rst = 1'b0;

    ea = {$urandom, $urandom}; dw = build(ea, 0, 9, 0);
    run(ea, dw, 0, "R7 leaf at root size 39");
    chk("R7", "root leaf size", 64'(page_size), 64'd39);

    ea = {$urandom, $urandom}; dw = build(ea, 3, 9, 0);
    run(ea, dw, 0, "R7 four levels w9");
    chk("R7", "4k leaf size", 64'(page_size), 64'd12);

    ea = {$urandom, $urandom}; dw = build(ea, 3, 5, 0);
    run(ea, dw, 0, "R7 four levels w5");
    chk("R7", "64k leaf size", 64'(page_size), 64'd16);

    ea = {$urandom, $urandom}; dw = build(ea, 2, 9, 1);
    run(ea, dw, 0, "R4 misaligned bases");

    ea = {$urandom, $urandom}; dw = build(ea, 3, 9, 0);
    mem[path[1]] = mem[path[1]] & ~(64'd1 << 63);
    run(ea, dw, 0, "R6 invalid level1");
    chk("R6", "invalid cause", 64'(cause), 64'd1);

    ea = {$urandom, $urandom}; dw = build(ea, 1, 9, 0);
    dw[4:0] = 5'd12;
    run(ea, dw, 0, "R5 bad root width");
    chk("R5", "no read at bad level", 64'(rd_count), 64'd0);

    ea = {$urandom, $urandom}; dw = build(ea, 4, 9, 0);
    run(ea, dw, 0, "R5 level4 illegal");
    chk("R5", "level4 cause", 64'(cause), 64'd2);

    ea = {$urandom, $urandom}; dw = build(ea, 3, 9, 0);
    mem[path[2]] = (mem[path[2]] & ~64'h1F) | 64'd7;
    run(ea, dw, 0, "R5 bad width level2");

    lat_cfg = 15;
    ea = {$urandom, $urandom}; dw = build(ea, 3, 5, 0);
    run(ea, dw, 1, "R10 slow memory and R2 restart");
    lat_cfg = -1;

    for (int v = 0; v < 300; v++) begin
      int depth, mode;
      ea = {$urandom, $urandom};
      depth = $urandom_range(0, 3);
      mode = $urandom_range(0, 5);
      dw = build(ea, depth, ($urandom_range(0, 1) != 0) ? 9 : 5, $urandom_range(0, 1) != 0);
      if (mode == 1) mem[path[$urandom_range(0, depth)]] = 64'd0;
      if (mode == 2 && depth > 0) begin
        int l;
        l = $urandom_range(0, depth - 1);
        mem[path[l]] = (mem[path[l]] & ~64'h1F) | 64'(6 + $urandom_range(0, 6));
      end
      if (mode == 3) dw[62:61] = 2'($urandom_range(0, 3));
      run(ea, dw, (v % 17) == 0 && depth == 3 && mode == 0, "R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule